// File: doc/BRIEF.md
# Serial Controller Status and Error Flag Unit

This block gathers the status of a serial controller into readable registers and raises one level interrupt. It keeps three flag registers: an operational word, a FIFO error word and a serial-clock error word. The operational word places four sticky event bits (count-done and service-request for each direction) beside four live FIFO level bits, which follow the FIFO status inputs.

Event sources arrive as one-cycle pulses or as levels on dedicated inputs. A set bit stays set until software writes a 1 into its position. Service software can therefore read a flag register and write the same value back to acknowledge exactly what it saw. An enable register gates each error word. A mask register gates the operational events. The interrupt output is high as long as any gated sticky bit remains set.

Register access uses a flat address, a write strobe and a combinational read port. Address codes: 0 operational word, 1 operational mask, 2 FIFO errors, 3 FIFO error enable, 4 clock errors, 5 clock error enable. Codes 6 and 7 read as zero and ignore writes.

Top module: `spi_flag_unit`

## Requirements
- R1: After synchronous reset, every sticky flag, enable and mask bit is 0, and irq is low.
- R2: The operational word (address 0) holds bit 11 input count done, bit 10 output count done, bit 9 input service request and bit 8 output service request. It also holds bit 7 input FIFO full, bit 6 output FIFO full, bit 5 input FIFO not empty and bit 4 output FIFO not empty. Bits 7:4 show the level inputs in the same cycle. All other bits read 0.
- R3: An event input that is high at a rising clock edge sets its sticky bit after that edge. The bit then stays set until it is cleared.
- R4: A write to a flag register (address 0, 2 or 4) clears each sticky bit whose position in the write data is 1. Bits written with 0 are left unchanged.
- R5: If an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R6: Writes to the live bits 7:4 and to the unused bits of any register have no effect. Writes to addresses 6 and 7 change no register. Addresses 6 and 7 read 0.
- R7: The FIFO error word (address 2) holds bit 5 output over-run, bit 4 input under-run, bit 3 output under-run and bit 2 input over-run. The clock error word (address 4) holds bit 1 clock over-run and bit 0 clock under-run.
- R8: The enable registers (address 3, bits 5:2; address 5, bits 1:0) and the mask register (address 1, bits 11:8, where 1 masks) read back what was written, in the same bit positions as their flags.
- R9: irq is high exactly when one of these holds: a FIFO error bit and its enable are both 1; a clock error bit and its enable are both 1; an operational sticky bit is 1 and its mask bit is 0.
- R10: Writing back the value just read from a flag register clears every sticky bit that was set. Afterwards irq is low if no other source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| in_fifo_full | input | 1 | Level: input FIFO full |
| out_fifo_full | input | 1 | Level: output FIFO full |
| in_fifo_nempty | input | 1 | Level: input FIFO not empty |
| out_fifo_nempty | input | 1 | Level: output FIFO not empty |
| in_count_done | input | 1 | Event: input word count reached |
| out_count_done | input | 1 | Event: output word count reached |
| in_svc_req | input | 1 | Event: input FIFO needs service |
| out_svc_req | input | 1 | Event: output FIFO needs service |
| out_overrun | input | 1 | Event: output FIFO over-run |
| in_underrun | input | 1 | Event: input FIFO under-run |
| out_underrun | input | 1 | Event: output FIFO under-run |
| in_overrun | input | 1 | Event: input FIFO over-run |
| sclk_overrun | input | 1 | Event: serial clock over-run |
| sclk_underrun | input | 1 | Event: serial clock under-run |
| irq | output | 1 | Level interrupt, active high |

## Verification
All state is flag bits read through a combinational port, so a wrong sticky bit shows up the cycle after the edge that set or cleared it. It is seen on the register read and usually on irq. The most likely fault is a lost event during a same-cycle clear. It appears as a bit reading 0 right after the clear edge, and as irq dropping while a new event is still pending. A wrong enable or mask bit leaves the flag word correct but inverts irq for that source in the same cycle, so irq has to be swept against every flag and gate combination.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    typedef enum logic [2:0] {
        A_OPSTAT  = 3'd0,
        A_OPMASK  = 3'd1,
        A_FIFOERR = 3'd2,
        A_FIFOEN  = 3'd3,
        A_CLKERR  = 3'd4,
        A_CLKEN   = 3'd5
    } reg_addr_e;

    localparam int OP_EVT_W   = 4;
    localparam int OP_EVT_LSB = 8;
    localparam int OP_LIV_W   = 4;
    localparam int OP_LIV_LSB = 4;
    localparam int FE_W       = 4;
    localparam int FE_LSB     = 2;
    localparam int CE_W       = 2;
    localparam int CE_LSB     = 0;
    localparam int MIN_DATA_W = OP_EVT_LSB + OP_EVT_W;

    typedef struct packed {
        logic in_done;
        logic out_done;
        logic in_svc;
        logic out_svc;
    } op_evt_t;

    typedef struct packed {
        logic in_full;
        logic out_full;
        logic in_nempty;
        logic out_nempty;
    } op_live_t;

    typedef struct packed {
        logic out_ovr;
        logic in_udr;
        logic out_udr;
        logic in_ovr;
    } fifo_err_t;

    typedef struct packed {
        logic clk_ovr;
        logic clk_udr;
    } clk_err_t;

    function automatic logic [31:0] place(input logic [31:0] field, input int lsb);
        return field << lsb;
    endfunction

endpackage

// File: rtl/spi_flag_sticky.sv
module spi_flag_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    always_ff @(posedge clk) begin
        if (rst)
            flags_o <= '0;
        else
            flags_o <= (flags_o & ~clr_i) | set_i;
    end

    // R3
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R4
    sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o));

endmodule

// File: rtl/spi_flag_cfg.sv
module spi_flag_cfg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
    import spi_flag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              in_fifo_full,
    input  logic              out_fifo_full,
    input  logic              in_fifo_nempty,
    input  logic              out_fifo_nempty,
    input  logic              in_count_done,
    input  logic              out_count_done,
    input  logic              in_svc_req,
    input  logic              out_svc_req,
    input  logic              out_overrun,
    input  logic              in_underrun,
    input  logic              out_underrun,
    input  logic              in_overrun,
    input  logic              sclk_overrun,
    input  logic              sclk_underrun,
    output logic              irq
);

    localparam int WD_W = (DATA_W > 32) ? 32 : DATA_W;

    op_evt_t   op_set, op_flags, op_mask;
    op_live_t  op_live;
    fifo_err_t fe_set, fe_flags, fe_en;
    clk_err_t  ce_set, ce_flags, ce_en;

    logic [31:0] wd;
    logic        hit_opstat, hit_opmask, hit_fe, hit_feen, hit_ce, hit_ceen;

    assign wd = 32'(reg_wdata[WD_W-1:0]);

    assign hit_opstat = reg_wr && (reg_addr == ADDR_W'(A_OPSTAT));
    assign hit_opmask = reg_wr && (reg_addr == ADDR_W'(A_OPMASK));
    assign hit_fe     = reg_wr && (reg_addr == ADDR_W'(A_FIFOERR));
    assign hit_feen   = reg_wr && (reg_addr == ADDR_W'(A_FIFOEN));
    assign hit_ce     = reg_wr && (reg_addr == ADDR_W'(A_CLKERR));
    assign hit_ceen   = reg_wr && (reg_addr == ADDR_W'(A_CLKEN));

    assign op_live = '{in_full: in_fifo_full, out_full: out_fifo_full,
                       in_nempty: in_fifo_nempty, out_nempty: out_fifo_nempty};
    assign op_set  = '{in_done: in_count_done, out_done: out_count_done,
                       in_svc: in_svc_req, out_svc: out_svc_req};
    assign fe_set  = '{out_ovr: out_overrun, in_udr: in_underrun,
                       out_udr: out_underrun, in_ovr: in_overrun};
    assign ce_set  = '{clk_ovr: sclk_overrun, clk_udr: sclk_underrun};

    // Sticky flag banks: write-one-to-clear, set dominates
    spi_flag_sticky #(.W(OP_EVT_W)) u_op_flags (
        .clk(clk), .rst(rst), .set_i(op_set),
        .clr_i(hit_opstat ? wd[OP_EVT_LSB +: OP_EVT_W] : '0),
        .flags_o(op_flags)
    );

    spi_flag_sticky #(.W(FE_W)) u_fe_flags (
        .clk(clk), .rst(rst), .set_i(fe_set),
        .clr_i(hit_fe ? wd[FE_LSB +: FE_W] : '0),
        .flags_o(fe_flags)
    );

    spi_flag_sticky #(.W(CE_W)) u_ce_flags (
        .clk(clk), .rst(rst), .set_i(ce_set),
        .clr_i(hit_ce ? wd[CE_LSB +: CE_W] : '0),
        .flags_o(ce_flags)
    );

    // Gating registers share their flags' bit positions
    spi_flag_cfg #(.W(OP_EVT_W)) u_op_mask (
        .clk(clk), .rst(rst), .we_i(hit_opmask),
        .d_i(wd[OP_EVT_LSB +: OP_EVT_W]), .q_o(op_mask)
    );

    spi_flag_cfg #(.W(FE_W)) u_fe_en (
        .clk(clk), .rst(rst), .we_i(hit_feen),
        .d_i(wd[FE_LSB +: FE_W]), .q_o(fe_en)
    );

    spi_flag_cfg #(.W(CE_W)) u_ce_en (
        .clk(clk), .rst(rst), .we_i(hit_ceen),
        .d_i(wd[CE_LSB +: CE_W]), .q_o(ce_en)
    );

    logic [31:0] rd32;

    always_comb begin
        case (reg_addr)
            ADDR_W'(A_OPSTAT):  rd32 = place(32'(op_flags), OP_EVT_LSB) |
                                       place(32'(op_live), OP_LIV_LSB);
            ADDR_W'(A_OPMASK):  rd32 = place(32'(op_mask), OP_EVT_LSB);
            ADDR_W'(A_FIFOERR): rd32 = place(32'(fe_flags), FE_LSB);
            ADDR_W'(A_FIFOEN):  rd32 = place(32'(fe_en), FE_LSB);
            ADDR_W'(A_CLKERR):  rd32 = place(32'(ce_flags), CE_LSB);
            ADDR_W'(A_CLKEN):   rd32 = place(32'(ce_en), CE_LSB);
            default:            rd32 = '0;
        endcase
    end

    assign reg_rdata = DATA_W'(rd32[WD_W-1:0]);

    assign irq = (|(op_flags & ~op_mask)) | (|(fe_flags & fe_en)) |
                 (|(ce_flags & ce_en));

    initial begin
        width_chk: assert (DATA_W >= MIN_DATA_W && ADDR_W >= 3);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq && op_flags == '0 && fe_flags == '0 && ce_flags == '0));

    // R9
    gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fe_en == '0 && ce_en == '0 && op_mask == '1) |-> !irq);

    // R6
    live_write_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_opstat && wd[OP_EVT_LSB +: OP_EVT_W] == '0) |=> $stable(op_mask));

endmodule

// File: tb/spi_flag_unit_test.sv
`timescale 1ns/100ps
module spi_flag_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [3:0]  live = '0, ev_op = '0, ev_fe = '0;
    logic [1:0]  ev_ce = '0;

    logic [3:0] m_op, m_mask, m_fe, m_fen;
    logic [1:0] m_ce, m_cen;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    spi_flag_unit uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_fifo_full(live[3]), .out_fifo_full(live[2]),
        .in_fifo_nempty(live[1]), .out_fifo_nempty(live[0]),
        .in_count_done(ev_op[3]), .out_count_done(ev_op[2]),
        .in_svc_req(ev_op[1]), .out_svc_req(ev_op[0]),
        .out_overrun(ev_fe[3]), .in_underrun(ev_fe[2]),
        .out_underrun(ev_fe[1]), .in_overrun(ev_fe[0]),
        .sclk_overrun(ev_ce[1]), .sclk_underrun(ev_ce[0]),
        .irq(irq)
    );

    function automatic logic [15:0] exp_read(input int a);
        case (a)
            0: return {4'b0, m_op, live, 4'b0};
            1: return {4'b0, m_mask, 8'b0};
            2: return {10'b0, m_fe, 2'b0};
            3: return {10'b0, m_fen, 2'b0};
            4: return {14'b0, m_ce};
            5: return {14'b0, m_cen};
            default: return 16'h0;
        endcase
    endfunction

    task automatic cmp(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic e_irq;
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #0.4;
            cmp(req, $sformatf("read addr %0d", a), reg_rdata, exp_read(a));
        end
        e_irq = (|(m_op & ~m_mask)) | (|(m_fe & m_fen)) | (|(m_ce & m_cen));
        cmp(req, "irq", 16'(irq), 16'(e_irq));
    endtask

    // one clock: optional write plus event pulses, then update model
    task automatic cycle(input logic wr, input int a, input logic [15:0] d,
                         input logic [3:0] eo, input logic [3:0] ef, input logic [1:0] ec);
        @(negedge clk);
        reg_wr = wr; reg_addr = 3'(a); reg_wdata = d;
        ev_op = eo; ev_fe = ef; ev_ce = ec;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; ev_op = '0; ev_fe = '0; ev_ce = '0;
        if (wr) begin
            case (a)
                0: m_op  = m_op & ~d[11:8];
                1: m_mask = d[11:8];
                2: m_fe  = m_fe & ~d[5:2];
                3: m_fen = d[5:2];
                4: m_ce  = m_ce & ~d[1:0];
                5: m_cen = d[1:0];
                default: ;
            endcase
        end
        m_op = m_op | eo;
        m_fe = m_fe | ef;
        m_ce = m_ce | ec;
    endtask

    task automatic wr_only(input int a, input logic [15:0] d);
        cycle(1'b1, a, d, 4'h0, 4'h0, 2'h0);
    endtask

    task automatic readback_clear(input int a, input string req);
        logic [15:0] v;
        @(negedge clk);
        reg_addr = 3'(a);
        #0.4;
        v = reg_rdata;
        wr_only(a, v);
        check_all(req);
    endtask

    initial begin
        m_op = '0; m_mask = '0; m_fe = '0; m_fen = '0; m_ce = '0; m_cen = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check_all("R1");

        // R2 live FIFO level bits follow inputs
        for (int p = 0; p < 16; p++) begin
            live = 4'(p);
            check_all("R2");
        end
        live = 4'b0101;

        // R3/R2 operational events, R10 readback clear
        for (int p = 1; p < 16; p++) begin
            cycle(1'b0, 0, 16'h0, 4'(p), 4'h0, 2'h0);
            check_all("R3");
            cycle(1'b0, 0, 16'h0, 4'h0, 4'h0, 2'h0);
            check_all("R3");
            readback_clear(0, "R10");
        end

        // R7 error words and R10
        for (int p = 1; p < 16; p++) begin
            cycle(1'b0, 0, 16'h0, 4'h0, 4'(p), 2'(p));
            check_all("R7");
            readback_clear(2, "R10");
            readback_clear(4, "R10");
        end

        // R4 partial clears leave other bits
        for (int c = 0; c < 16; c++) begin
            cycle(1'b0, 0, 16'h0, 4'hF, 4'hF, 2'h3);
            wr_only(0, 16'(c) << 8);
            wr_only(2, 16'(c) << 2);
            wr_only(4, 16'(c & 3));
            check_all("R4");
        end

        // R5 event in clear cycle keeps bit set
        for (int p = 0; p < 16; p++) begin
            cycle(1'b0, 0, 16'h0, 4'hF, 4'hF, 2'h3);
            cycle(1'b1, 0, 16'hFFFF, 4'(p), 4'h0, 2'h0);
            cycle(1'b1, 2, 16'hFFFF, 4'h0, 4'(p), 2'h0);
            cycle(1'b1, 4, 16'hFFFF, 4'h0, 4'h0, 2'(p));
            check_all("R5");
        end

        // R6 writes to live/unused bits and to unused addresses
        wr_only(0, 16'hFFFF);
        wr_only(2, 16'hFFFF);
        wr_only(4, 16'hFFFF);
        cycle(1'b0, 0, 16'h0, 4'hA, 4'h5, 2'h2);
        wr_only(0, 16'hF0FF);
        wr_only(6, 16'hFFFF);
        wr_only(7, 16'hFFFF);
        check_all("R6");
        wr_only(1, 16'hF0FF);
        wr_only(3, 16'hFFC3);
        wr_only(5, 16'hFFFC);
        check_all("R6");

        // R8 enable and mask read-back
        for (int v = 0; v < 16; v++) begin
            wr_only(1, 16'hFFFF & (16'(v) << 8));
            wr_only(3, 16'(v) << 2);
            wr_only(5, 16'(v & 3));
            check_all("R8");
        end

        // R9 irq sweep: every flag vs gate pattern
        wr_only(1, 16'h0F00);
        wr_only(3, 16'h0000);
        wr_only(5, 16'h0000);
        for (int f = 0; f < 16; f++) begin
            for (int g = 0; g < 16; g++) begin
                wr_only(0, 16'h0F00);
                wr_only(2, 16'h003C);
                wr_only(4, 16'h0003);
                cycle(1'b0, 0, 16'h0, 4'h0, 4'(f), 2'(f & 3));
                wr_only(3, 16'(g) << 2);
                wr_only(5, 16'(g & 3));
                check_all("R9");
            end
        end
        wr_only(3, 16'h0);
        wr_only(5, 16'h0);
        readback_clear(2, "R9");
        readback_clear(4, "R9");
        for (int f = 0; f < 16; f++) begin
            for (int g = 0; g < 16; g++) begin
                wr_only(0, 16'h0F00);
                wr_only(1, 16'(g) << 8);
                cycle(1'b0, 0, 16'h0, 4'(f), 4'h0, 2'h0);
                check_all("R9");
            end
        end

        // R10 final clear of everything drops irq
        wr_only(1, 16'h0);
        cycle(1'b0, 0, 16'h0, 4'hF, 4'hF, 2'h3);
        wr_only(3, 16'h003C);
        wr_only(5, 16'h0003);
        readback_clear(0, "R10");
        readback_clear(2, "R10");
        readback_clear(4, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule